// File: doc/BRIEF.md
# Multiplexed Address/Data Bus Interface

This block is the external bus unit used when the core runs in expanded mode. It turns a CPU read or write request into one cycle on a multiplexed external bus. The upper address byte is driven on a dedicated 8-bit port for the whole cycle. A second 8-bit port is shared. It carries the lower address byte while E is low, then carries data while E is high. Its direction during the data half follows R/W.

A bus cycle lasts two clocks. In the first clock E is low, the address strobe is high and both address bytes are on the pins. In the second clock E is high. On a write the shared port drives the write data. On a read the port is released, and the value on its pins is captured at the clock edge where E falls. One clock after E falls, a single-clock acknowledge returns the result to the CPU.

Requests that the on-chip decoder claims are normally left to on-chip logic. The one exception is the address of the high-byte port data register. That port is in use as the address bus, so the block sends accesses to that address out to the external bus.

The pad ring joins `ad_o`, `ad_i` and `ad_oe_o` into the eight shared pins.

Top module: `mux_bus_unit`

## Requirements
- R1: While reset is asserted and after it is released with no request: `e_o`=0, `as_o`=0, `ad_oe_o`=0, `rw_o`=1 (1 means read) and `ack_o`=0.
- R2: A request is accepted at a rising clock edge when it is external, the unit is idle and `ack_o` is low. In the following clock (the address phase), `e_o`=0 and `as_o`=1. `hi_addr_o` carries address bits 15..8 and `ad_o` carries address bits 7..0. `ad_oe_o`=1 and `rw_o` is the inverse of `we_i`.
- R3: The clock after the address phase is the data phase. In it, `e_o`=1 and `as_o`=0, while `hi_addr_o` and `rw_o` keep their address-phase values.
- R4: In the data phase of a write, `ad_oe_o`=1 and `ad_o` carries the write data.
- R5: In the data phase of a read, `ad_oe_o`=0. The value on `ad_i` at the edge that ends the data phase appears on `rdata_o` in the next clock.
- R6: `ack_o` is high for exactly the one clock after each data phase, for reads and writes alike. A write leaves `rdata_o` unchanged.
- R7: A request with `int_hit_i`=1 to any address other than `HI_PORT_ADDR` starts no bus cycle and gives no acknowledge. The bus stays idle while such a request is held.
- R8: A request to `HI_PORT_ADDR` runs an external bus cycle even when `int_hit_i`=1.
- R9: Outside the address and data phases, `ad_oe_o`=0, `rw_o`=1, `as_o`=0 and `e_o`=0.
- R10: Address, write data and direction are captured when a request is accepted. Changes on `addr_i`, `wdata_i` or `we_i` during the cycle do not reach the pins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock; one bus phase per clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_i | input | 1 | CPU access request, held until acknowledged |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 16 | CPU address |
| wdata_i | input | 8 | CPU write data |
| int_hit_i | input | 1 | On-chip decoder claims the address |
| rdata_o | output | 8 | Read data returned to the CPU |
| ack_o | output | 1 | One-clock completion pulse |
| hi_addr_o | output | 8 | Upper address byte port |
| ad_o | output | 8 | Shared port output value (low address or write data) |
| ad_i | input | 8 | Shared port pin level |
| ad_oe_o | output | 1 | Shared port output enable |
| e_o | output | 1 | E clock phase, high in the data phase |
| as_o | output | 1 | Address strobe, high in the address phase |
| rw_o | output | 1 | Bus direction, 1 = read |

## Verification
The properties assume a CPU that holds `req_i` until `ack_o` and that never starts a cycle from any state other than idle. Under that assumption, E, the strobe and R/W follow a strict address-then-data order. The stimulus raises a request only when the bench sees the unit idle and drops it in the acknowledge clock. It changes address and data only after the address phase, which tests the capture rule.

// File: rtl/mux_bus_pkg.sv
package mux_bus_pkg;
  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_ADDR = 2'd1,
    PH_DATA = 2'd2
  } phase_e;
endpackage

// File: rtl/mux_bus_decode.sv
module mux_bus_decode #(
  parameter int          AW           = 16,
  parameter logic [15:0] HI_PORT_ADDR = 16'h0104
) (
  input  logic [AW-1:0] addr_i,
  input  logic          int_hit_i,
  output logic          ext_o
);
  logic port_hit;
  // high-byte port register is remapped out in expanded mode
  assign port_hit = (addr_i == HI_PORT_ADDR[AW-1:0]);
  assign ext_o    = !int_hit_i || port_hit;
endmodule

// File: rtl/mux_bus_seq.sv
module mux_bus_seq
  import mux_bus_pkg::*;
(
  input  logic   clk_i,
  input  logic   rst_ni,
  input  logic   req_i,
  input  logic   ext_i,
  output phase_e phase_o,
  output logic   accept_o,
  output logic   ack_o
);
  phase_e phase_q;
  logic   ack_q;

  assign accept_o = (phase_q == PH_IDLE) && req_i && ext_i && !ack_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= PH_IDLE;
      ack_q   <= 1'b0;
    end else begin
      ack_q <= (phase_q == PH_DATA);
      unique case (phase_q)
        PH_IDLE: if (accept_o) phase_q <= PH_ADDR;
        PH_ADDR: phase_q <= PH_DATA;
        default: phase_q <= PH_IDLE;
      endcase
    end
  end

  assign phase_o = phase_q;
  assign ack_o   = ack_q;
endmodule

// File: rtl/mux_bus_path.sv
module mux_bus_path
  import mux_bus_pkg::*;
#(
  parameter int AW = 16,
  parameter int DW = 8
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            accept_i,
  input  phase_e          phase_i,
  input  logic [AW-1:0]   addr_i,
  input  logic            we_i,
  input  logic [DW-1:0]   wdata_i,
  input  logic [DW-1:0]   ad_i,
  output logic [AW-DW-1:0] hi_addr_o,
  output logic [DW-1:0]   ad_o,
  output logic            ad_oe_o,
  output logic            e_o,
  output logic            as_o,
  output logic            rw_o,
  output logic [DW-1:0]   rdata_o
);
  localparam int HW = AW - DW;

  logic [AW-1:0] addr_q;
  logic [DW-1:0] wdata_q;
  logic          we_q;
  logic [DW-1:0] rdata_q;
  logic          in_addr, in_data;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q  <= '0;
      wdata_q <= '0;
      we_q    <= 1'b0;
    end else if (accept_i) begin
      addr_q  <= addr_i;
      wdata_q <= wdata_i;
      we_q    <= we_i;
    end
  end

  // sample read data on the edge where E falls
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                           rdata_q <= '0;
    else if (phase_i == PH_DATA && !we_q)  rdata_q <= ad_i;
  end

  assign in_addr = (phase_i == PH_ADDR);
  assign in_data = (phase_i == PH_DATA);

  assign hi_addr_o = addr_q[AW-1 -: HW];
  assign ad_o      = in_data ? wdata_q : addr_q[DW-1:0];
  assign ad_oe_o   = in_addr || (in_data && we_q);
  assign e_o       = in_data;
  assign as_o      = in_addr;
  assign rw_o      = (in_addr || in_data) ? !we_q : 1'b1;
  assign rdata_o   = rdata_q;
endmodule

// File: rtl/mux_bus_unit.sv
module mux_bus_unit
  import mux_bus_pkg::*;
#(
  parameter int          AW           = 16,
  parameter int          DW           = 8,
  parameter logic [15:0] HI_PORT_ADDR = 16'h0104
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_i,
  input  logic             we_i,
  input  logic [AW-1:0]    addr_i,
  input  logic [DW-1:0]    wdata_i,
  input  logic             int_hit_i,
  output logic [DW-1:0]    rdata_o,
  output logic             ack_o,
  output logic [AW-DW-1:0] hi_addr_o,
  output logic [DW-1:0]    ad_o,
  input  logic [DW-1:0]    ad_i,
  output logic             ad_oe_o,
  output logic             e_o,
  output logic             as_o,
  output logic             rw_o
);
  logic   ext;
  logic   accept;
  phase_e phase;

  mux_bus_decode #(.AW(AW), .HI_PORT_ADDR(HI_PORT_ADDR)) u_dec (
    .addr_i   (addr_i),
    .int_hit_i(int_hit_i),
    .ext_o    (ext)
  );

  mux_bus_seq u_seq (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .req_i   (req_i),
    .ext_i   (ext),
    .phase_o (phase),
    .accept_o(accept),
    .ack_o   (ack_o)
  );

  mux_bus_path #(.AW(AW), .DW(DW)) u_path (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .accept_i (accept),
    .phase_i  (phase),
    .addr_i   (addr_i),
    .we_i     (we_i),
    .wdata_i  (wdata_i),
    .ad_i     (ad_i),
    .hi_addr_o(hi_addr_o),
    .ad_o     (ad_o),
    .ad_oe_o  (ad_oe_o),
    .e_o      (e_o),
    .as_o     (as_o),
    .rw_o     (rw_o),
    .rdata_o  (rdata_o)
  );
endmodule

// File: rtl/mux_bus_chk.sv
module mux_bus_chk #(
  parameter int HW = 8
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          e_o,
  input logic          as_o,
  input logic          rw_o,
  input logic          ad_oe_o,
  input logic          ack_o,
  input logic [HW-1:0] hi_addr_o
);
  p_strobe_e_low_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    as_o |-> !e_o);
  p_strobe_then_e_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    as_o |=> (e_o && !as_o));
  p_e_single_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    e_o |=> !e_o);
  p_hold_in_data_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    e_o |-> ($stable(hi_addr_o) && $stable(rw_o)));
  p_write_drives_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (e_o && !rw_o) |-> ad_oe_o);
  p_read_released_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (e_o && rw_o) |-> !ad_oe_o);
  p_ack_after_e_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    e_o |=> ack_o);
  p_ack_single_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_o |=> !ack_o);
  p_idle_quiet_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!as_o && !e_o) |-> (!ad_oe_o && rw_o));
endmodule

bind mux_bus_unit mux_bus_chk #(.HW(AW-DW)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .e_o      (e_o),
  .as_o     (as_o),
  .rw_o     (rw_o),
  .ad_oe_o  (ad_oe_o),
  .ack_o    (ack_o),
  .hi_addr_o(hi_addr_o)
);

// File: tb/sim_mux_bus_unit.sv
module sim_mux_bus_unit;
  localparam int CLK_PERIOD = 10;
  localparam logic [15:0] PORT_ADDR = 16'h0104;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req_i = 1'b0, we_i = 1'b0, int_hit_i = 1'b0;
  logic [15:0] addr_i = '0;
  logic [7:0]  wdata_i = '0, ad_i = '0;
  logic [7:0]  rdata_o, hi_addr_o, ad_o;
  logic        ack_o, ad_oe_o, e_o, as_o, rw_o;

  int n_chk = 0, n_fail = 0;
  logic [7:0] last_rd = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mux_bus_unit #(.HI_PORT_ADDR(PORT_ADDR)) u0 (
    .clk_i(clk), .rst_ni(rst_ni), .req_i(req_i), .we_i(we_i), .addr_i(addr_i),
    .wdata_i(wdata_i), .int_hit_i(int_hit_i), .rdata_o(rdata_o), .ack_o(ack_o),
    .hi_addr_o(hi_addr_o), .ad_o(ad_o), .ad_i(ad_i), .ad_oe_o(ad_oe_o),
    .e_o(e_o), .as_o(as_o), .rw_o(rw_o)
  );

  task automatic chk(input bit ok, input string tag, input logic [15:0] act,
                     input logic [15:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic chk_idle(input string tag);
    chk({e_o, as_o, ad_oe_o, rw_o} == 4'b0001, tag,
        {12'h0, e_o, as_o, ad_oe_o, rw_o}, 16'h0001);
  endtask

  // one full bus cycle driven from the CPU side; samples at negedges
  task automatic bus_cycle(input bit we, input logic [15:0] a, input logic [7:0] wd,
                           input bit ih, input logic [7:0] rv);
    we_i = we; addr_i = a; wdata_i = wd; int_hit_i = ih; req_i = 1'b1;
    @(negedge clk);
    // address phase
    chk({e_o, as_o, ad_oe_o} == 3'b011, "R2 phase", {13'h0, e_o, as_o, ad_oe_o}, 16'h3);
    chk({hi_addr_o, ad_o} == a, "R2 addr", {hi_addr_o, ad_o}, a);
    chk(rw_o == !we, "R2 rw", {15'h0, rw_o}, {15'h0, !we});
    // corrupt CPU-side inputs: pins must not follow (R10)
    addr_i = ~a; wdata_i = ~wd; we_i = !we; ad_i = rv;
    @(negedge clk);
    chk({e_o, as_o} == 2'b10, "R3 phase", {14'h0, e_o, as_o}, 16'h2);
    chk(hi_addr_o == a[15:8] && rw_o == !we, "R3 R10 hold",
        {hi_addr_o, 7'h0, rw_o}, {a[15:8], 7'h0, !we});
    if (we) begin
      chk(ad_oe_o && ad_o == wd, "R4 R10 wdata", {7'h0, ad_oe_o, ad_o}, {8'h1, wd});
    end else begin
      chk(!ad_oe_o, "R5 released", {15'h0, ad_oe_o}, 16'h0);
    end
    @(negedge clk);
    req_i = 1'b0;
    ad_i = ~rv;
    chk(ack_o, "R6 ack", {15'h0, ack_o}, 16'h1);
    chk_idle("R9 ack clock");
    if (!we) last_rd = rv;
    chk(rdata_o == last_rd, we ? "R6 rdata kept" : "R5 rdata",
        {8'h0, rdata_o}, {8'h0, last_rd});
    @(negedge clk);
    chk(!ack_o, "R6 ack single", {15'h0, ack_o}, 16'h0);
    chk_idle("R9 after");
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 2);
    @(negedge clk);
    chk_idle("R1 in reset");
    chk(!ack_o, "R1 ack", {15'h0, ack_o}, 16'h0);
    rst_ni = 1'b1;
    @(negedge clk);
    @(negedge clk);
    chk_idle("R1 after reset");
    chk(!ack_o && rdata_o == 8'h0, "R1 ack/rdata", {7'h0, ack_o, rdata_o}, 16'h0);

    // sweep of address bytes, read and write
    for (int i = 0; i < 256; i++) begin
      logic [7:0] b = 8'(i);
      bus_cycle(1'b0, {b, ~b}, 8'h00, 1'b0, b ^ 8'h5a);
      bus_cycle(1'b1, {~b, b}, 8'(i * 3 + 1), 1'b0, 8'h00);
    end

    // R7: internally claimed addresses stay off the bus
    for (int k = 0; k < 2; k++) begin
      addr_i = (k == 0) ? 16'h0105 : 16'h0004;
      int_hit_i = 1'b1; we_i = 1'b0; req_i = 1'b1;
      for (int c = 0; c < 4; c++) begin
        @(negedge clk);
        chk(!e_o && !as_o && !ack_o, "R7 no cycle",
            {13'h0, e_o, as_o, ack_o}, 16'h0);
      end
      req_i = 1'b0;
      @(negedge clk);
    end

    // R8: port register address goes external despite internal claim
    bus_cycle(1'b0, PORT_ADDR, 8'h00, 1'b1, 8'hc3);
    bus_cycle(1'b1, PORT_ADDR, 8'h3c, 1'b1, 8'h00);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule